// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device out of power-up before the memory controller begins normal traffic. When reset is released it issues a fixed series of commands on a command port, with the required idle time after each one. It holds the refresh request low for the whole series. When the series ends it switches refresh on according to the timing configuration and raises a done flag.

The mode-register payload carried with the commands is worked out in hardware. It depends on the CAS latency field of the timing configuration word and on the bus-width bit of the bank-group configuration word. Software can replace the calculated payload with its own value by driving a nonzero override. Both wait times are given in nanoseconds and converted to clock cycles from a clock-frequency parameter, rounding up. At the default 50 MHz this gives 10000 idle cycles after the first command and 4 idle cycles after each later one.

Top module: `sdram_init_seq`

## Requirements
- R1: With `mode_override` zero, the payload is 0x40 for CAS latency 2 on a 32-bit bus, 0x60 for latency 3 on a 32-bit bus, 0x20 for latency 2 on a 16-bit bus and 0x30 for latency 3 on a 16-bit bus. Latency comes from `timing_cfg[2:0]`: the value 2 selects latency 2 and every other value selects latency 3. `grp_cfg[9]` set means a 16-bit bus.
- R2: A nonzero `mode_override` is used as the payload in place of the calculated value.
- R3: `cmd_word` carries the payload in bits [9:2] and the command code in bits [1:0]. The code is also on `cmd_code`. The codes are NOP=0, PRECHARGE=1, REFRESH=2 and MODE SET=3.
- R4: Every command is presented with `cmd_valid` high for exactly one clock cycle.
- R5: After reset the commands come in this order: one NOP, one PRECHARGE, eight REFRESH, one MODE SET. No other command is issued.
- R6: Exactly ceil(200 us x clock) idle cycles separate the NOP strobe from the PRECHARGE strobe (10000 at 50 MHz).
- R7: Exactly ceil(80 ns x clock) idle cycles separate each later strobe from the next one (4 at 50 MHz).
- R8: `refresh_en` stays low until `init_done` is set. After that it is high only if the refresh field `timing_cfg[5:4]` is nonzero.
- R9: `init_done` first reads high ceil(80 ns x clock)+1 cycles after the MODE SET strobe and stays high until the next reset. No command is issued while it is high.
- R10: While reset is asserted all outputs are low. A reset in the middle of the series restarts it from the NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grp_cfg | input | 32 | Bank-group configuration word; bit 9 selects a 16-bit bus |
| timing_cfg | input | 32 | Timing configuration; [2:0] CAS latency, [5:4] refresh enable |
| mode_override | input | 8 | Mode payload override; zero means use the calculated value |
| cmd_code | output | 2 | Command code of the current strobe |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_word | output | 10 | Payload in [9:2], command code in [1:0] |
| refresh_en | output | 1 | Refresh request, held low during initialization |
| init_done | output | 1 | Initialization finished, sticky until reset |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of the refresh burst. To get there, the stimulus counts strobes, pulls reset after the fourth one, checks that every output drops, and then follows the complete restarted series from its NOP. The second-hardest case is the 10000-cycle power-up gap. Each vector in the table runs the full series and measures the gap strobe to strobe, so an off-by-one error in the cycle conversion or in the counter reload is exposed every time.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_MRS = 2'd3
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  function automatic int ns_to_cycles(input longint clk_hz, input longint ns);
    longint c;
    c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction
endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/sdram_mode_calc.sv
module sdram_mode_calc #(
  parameter int MODE_W  = 8,
  parameter int CAS_W   = 3,
  parameter logic [MODE_W-1:0] CL2_WORD = 8'h40,
  parameter logic [MODE_W-1:0] CL3_WORD = 8'h60
) (
  input  logic [CAS_W-1:0]  cas_field,
  input  logic              narrow_bus,
  input  logic [MODE_W-1:0] override_val,
  output logic [MODE_W-1:0] payload
);
  logic [MODE_W-1:0] wide_word;
  logic [MODE_W-1:0] calc_word;

  always_comb begin
    wide_word = (cas_field == CAS_W'(2)) ? CL2_WORD : CL3_WORD;
    calc_word = narrow_bus ? (wide_word >> 1) : wide_word;
    payload   = (override_val != '0) ? override_val : calc_word;
  end
endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int TW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  p_tick_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == TW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PWRUP_NS  = 200_000,
  parameter int GAP_NS    = 80,
  parameter int REF_COUNT = 8,
  parameter int CFG_W     = 32,
  parameter int MODE_W    = 8,
  parameter int CAS_LSB   = 0,
  parameter int CAS_W     = 3,
  parameter int WIDTH_BIT = 9,
  parameter int REF_LSB   = 4,
  parameter int REF_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  grp_cfg,
  input  logic [CFG_W-1:0]  timing_cfg,
  input  logic [MODE_W-1:0] mode_override,
  output logic [1:0]        cmd_code,
  output logic              cmd_valid,
  output logic [MODE_W+1:0] cmd_word,
  output logic              refresh_en,
  output logic              init_done
);
  localparam int PWRUP_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(PWRUP_NS));
  localparam int GAP_CYC   = ns_to_cycles(longint'(CLK_HZ), longint'(GAP_NS));
  localparam int LONGEST   = (PWRUP_CYC > GAP_CYC) ? PWRUP_CYC : GAP_CYC;
  localparam int TW        = $clog2(LONGEST + 1);
  localparam int RCW       = $clog2(REF_COUNT + 1);
  localparam logic [TW-1:0]  PW_LOAD  = TW'(PWRUP_CYC - 1);
  localparam logic [TW-1:0]  GAP_LOAD = TW'(GAP_CYC - 1);
  localparam logic [RCW-1:0] REF_LAST = RCW'(REF_COUNT - 1);

  logic rst_sync_n;
  sdram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [MODE_W-1:0] payload;
  sdram_mode_calc #(
    .MODE_W (MODE_W),
    .CAS_W  (CAS_W)
  ) u_mode (
    .cas_field    (timing_cfg[CAS_LSB +: CAS_W]),
    .narrow_bus   (grp_cfg[WIDTH_BIT]),
    .override_val (mode_override),
    .payload      (payload)
  );

  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_exp;
  sdram_wait_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  seq_state_e st_q, st_d;
  sdram_cmd_e ph_q, ph_d;
  logic [RCW-1:0] rc_q, rc_d;
  logic step_en;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    rc_d   = rc_q;
    t_load = 1'b0;
    t_val  = GAP_LOAD;
    case (st_q)
      ST_BOOT: st_d = ST_ISSUE;
      ST_ISSUE: begin
        t_load = 1'b1;
        t_val  = (ph_q == CMD_NOP) ? PW_LOAD : GAP_LOAD;
        st_d   = ST_WAIT;
      end
      ST_WAIT: begin
        if (t_exp) begin
          st_d = ST_ISSUE;
          case (ph_q)
            CMD_NOP: ph_d = CMD_PRE;
            CMD_PRE: begin
              ph_d = CMD_REF;
              rc_d = '0;
            end
            CMD_REF: begin
              if (rc_q == REF_LAST) ph_d = CMD_MRS;
              else                  rc_d = rc_q + 1'b1;
            end
            default: st_d = ST_DONE;
          endcase
        end
      end
      default: st_d = ST_DONE;
    endcase
    step_en = (st_d != st_q) || (ph_d != ph_q) || (rc_d != rc_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q <= ST_BOOT;
      ph_q <= CMD_NOP;
      rc_q <= '0;
    end else if (step_en) begin
      st_q <= st_d;
      ph_q <= ph_d;
      rc_q <= rc_d;
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{grp_cfg, timing_cfg};

  always_comb begin
    cmd_valid  = (st_q == ST_ISSUE);
    cmd_code   = cmd_valid ? ph_q : CMD_NOP;
    cmd_word   = cmd_valid ? {payload, ph_q} : '0;
    init_done  = (st_q == ST_DONE);
    refresh_en = init_done && (timing_cfg[REF_LSB +: REF_W] != '0);
  end

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_valid |=> !cmd_valid);
  p_refresh_held_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !init_done |-> !refresh_en);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_done |=> init_done);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_done |-> !cmd_valid);
  p_strobe_after_wait_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_WAIT && !t_exp) |=> !cmd_valid);
endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int PW  = (50 * 200_000 + 999) / 1000;
  localparam int GP  = (50 * 80 + 999) / 1000;
  localparam int NV  = 7;
  localparam int NCMD = 11;

  localparam logic [80:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0012, 8'h00, 8'h40, 1'b1},
    {32'h0000_0000, 32'h0000_0033, 8'h00, 8'h60, 1'b1},
    {32'h0000_0200, 32'h0000_0022, 8'h00, 8'h20, 1'b1},
    {32'h0000_0200, 32'h0000_0003, 8'h00, 8'h30, 1'b0},
    {32'h0000_0200, 32'h0000_0017, 8'h00, 8'h30, 1'b1},
    {32'hFFFF_FDFF, 32'h0000_0010, 8'h00, 8'h60, 1'b1},
    {32'h0000_0000, 32'h0000_0012, 8'h5A, 8'h5A, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] grp_cfg;
  logic [31:0] timing_cfg;
  logic [7:0]  mode_override;
  logic [1:0]  cmd_code;
  logic        cmd_valid;
  logic [9:0]  cmd_word;
  logic        refresh_en;
  logic        init_done;

  int total = 0;
  int bad = 0;

  sdram_init_seq uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .grp_cfg       (grp_cfg),
    .timing_cfg    (timing_cfg),
    .mode_override (mode_override),
    .cmd_code      (cmd_code),
    .cmd_valid     (cmd_valid),
    .cmd_word      (cmd_word),
    .refresh_en    (refresh_en),
    .init_done     (init_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input int k);
    if (k == 0) return 2'd0;
    if (k == 1) return 2'd1;
    if (k == NCMD - 1) return 2'd3;
    return 2'd2;
  endfunction

  task automatic run_seq(input logic [31:0] g, input logic [31:0] t, input logic [7:0] ov,
                         input logic [7:0] exp_pl, input logic exp_ref);
    int stamp [NCMD];
    logic [1:0] codes [NCMD];
    logic [9:0] words [NCMD];
    int nstr = 0;
    int first_done = -1;
    logic ref_early = 1'b0;
    logic wide_pulse = 1'b0;
    logic done_drop = 1'b0;
    logic code_bad = 1'b0;
    logic word_bad = 1'b0;
    logic gap_bad = 1'b0;
    logic prev_v = 1'b0;
    logic ref_after = 1'b0;
    @(negedge clk);
    grp_cfg = g;
    timing_cfg = t;
    mode_override = ov;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs low while reset is held
    check({cmd_valid, cmd_code, cmd_word, refresh_en, init_done} == '0, "R10 reset outputs",
          {cmd_valid, cmd_code, cmd_word, refresh_en, init_done}, 0);
    rst_n = 1'b1;
    for (int idx = 0; idx < PW + 200; idx++) begin
      @(negedge clk);
      if (cmd_valid) begin
        if (prev_v) wide_pulse = 1'b1;
        if (nstr < NCMD) begin
          stamp[nstr] = idx;
          codes[nstr] = cmd_code;
          words[nstr] = cmd_word;
        end
        nstr++;
      end
      prev_v = cmd_valid;
      if (!init_done && refresh_en) ref_early = 1'b1;
      if (first_done >= 0 && !init_done) done_drop = 1'b1;
      if (init_done && first_done < 0) first_done = idx;
      if (init_done) ref_after = refresh_en;
      if (first_done >= 0 && idx >= first_done + 4) break;
    end
    check(nstr == NCMD, "R5 command count", nstr, NCMD);
    if (nstr == NCMD) begin
      for (int k = 0; k < NCMD; k++) begin
        if (codes[k] != exp_code(k)) code_bad = 1'b1;
        if (words[k] != {exp_pl, exp_code(k)}) word_bad = 1'b1;
        if (k >= 2 && stamp[k] - stamp[k-1] - 1 != GP) gap_bad = 1'b1;
      end
      check(!code_bad, "R5 command order", codes[NCMD-1], 3);
      check(!word_bad, (ov != 0) ? "R2 override payload R3" : "R1 payload R3",
            words[NCMD-1], {exp_pl, 2'd3});
      check(stamp[1] - stamp[0] - 1 == PW, "R6 power-up gap", stamp[1] - stamp[0] - 1, PW);
      check(!gap_bad, "R7 command gap", gap_bad, 0);
      check(first_done - stamp[NCMD-1] == GP + 1, "R9 done delay",
            first_done - stamp[NCMD-1], GP + 1);
    end
    check(!wide_pulse, "R4 single-cycle strobe", wide_pulse, 0);
    check(!ref_early, "R8 refresh held low", ref_early, 0);
    check(ref_after == exp_ref, "R8 refresh after done", ref_after, exp_ref);
    check(first_done >= 0 && !done_drop, "R9 done sticky", done_drop, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    grp_cfg = '0;
    timing_cfg = '0;
    mode_override = '0;
    for (int v = 0; v < NV; v++) begin
      run_seq(VEC[v][80:49], VEC[v][48:17], VEC[v][16:9], VEC[v][8:1], VEC[v][0]);
    end
    // R10: reset in the middle of the refresh burst
    begin
      int seen = 0;
      @(negedge clk);
      rst_n = 1'b0;
      grp_cfg = 32'h0;
      timing_cfg = 32'h12;
      mode_override = 8'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int idx = 0; idx < PW + 100 && seen < 4; idx++) begin
        @(negedge clk);
        if (cmd_valid) seen++;
      end
      check(seen == 4, "R10 reached refresh burst", seen, 4);
      rst_n = 1'b0;
      @(negedge clk);
      check({cmd_valid, init_done, refresh_en} == 3'b000, "R10 mid-run reset outputs",
            {cmd_valid, init_done, refresh_en}, 0);
      run_seq(32'h0, 32'h12, 8'h0, 8'h40, 1'b1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190_000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule